// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel bytes into asynchronous serial frames on a single output line. A byte is placed in a one-entry holding stage with a write strobe. When the serializer is free, the byte moves into a shift stage and goes out as a frame: a low start bit, 5 to 8 data bits with the least significant bit first, an optional even or odd parity bit, and a high stop period of one, one and a half or two bit times. The line rests high between frames.

The bit rate comes from a 16-bit divisor: each bit lasts sixteen sub-ticks, and each sub-tick lasts the divisor's value in system clocks, with the value 0 meaning 65536. Word length, parity, stop length and divisor are captured when a byte moves into the shift stage, so the format of a frame never changes part way through it. Two status outputs tell the surrounding logic when the holding stage can take another byte and when the whole transmitter has gone quiet.

Top module: `async_tx`

## Requirements
- R1: While reset is asserted and right after it, `txd` is 1, `holdEmpty` is 1 and `txEmpty` is 1.
- R2: Every start, data and parity bit lasts exactly 16 × D system clocks, where D is the `divisor` value (1 to 65535) captured when the frame began.
- R3: A `divisor` value of 0 gives D = 65536.
- R4: The data bits follow the start bit least significant bit first; `wordLen` codes 0, 1, 2, 3 select 5, 6, 7, 8 data bits, and upper bits of the written byte beyond the selected length are not sent.
- R5: With `parityEn` = 1 one parity bit follows the last data bit; with `parityOdd` = 0 it makes the count of ones over data and parity even, with `parityOdd` = 1 odd. With `parityEn` = 0 no parity bit is sent.
- R6: The stop period holds `txd` at 1 for 16 × D clocks when `twoStop` = 0, 24 × D clocks when `twoStop` = 1 and `wordLen` = 0, and 32 × D clocks when `twoStop` = 1 with any other word length.
- R7: A byte written at a clock edge makes `holdEmpty` 0 after that edge; if the transmitter is idle, at the following edge the byte moves to the shift stage, `holdEmpty` returns to 1 and `txd` goes low for the start bit.
- R8: If the holding stage is full when a stop period ends, the next start bit begins at that same edge with no idle time on the line.
- R9: `txEmpty` is 1 only when no frame is being sent and the holding stage is empty; it stays 1 until a byte is written.
- R10: A write while the holding stage is full replaces the held byte; only the latest byte is sent.
- R11: Changes to `divisor`, `wordLen`, `parityEn`, `parityOdd` or `twoStop` during a frame do not affect that frame; they take effect at the next transfer into the shift stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| divisor | input | 16 | Clocks per sixteenth of a bit; 0 means 65536 |
| wordLen | input | 2 | Data bit count minus five |
| twoStop | input | 1 | Long stop period select |
| parityEn | input | 1 | Append a parity bit |
| parityOdd | input | 1 | Parity sense: 1 odd, 0 even |
| wrEn | input | 1 | Write strobe for the holding stage |
| wrData | input | 8 | Byte to send |
| txd | output | 1 | Serial output line, idles high |
| holdEmpty | output | 1 | Holding stage can accept a byte |
| txEmpty | output | 1 | No frame in progress and nothing held |

## Verification
A wrong sub-tick or bit counter shows as an edge on `txd` that lands earlier or later than the 16 × D boundary, visible within the first bit of the frame; a wrong parity or shift state shows as a wrong line level in the affected bit period. A stuck holding flag shows one clock after a write or a transfer on `holdEmpty` and `txEmpty`, and a missed chained transfer shows as a high gap or a missing start bit at the end of the stop period. Comparing every line level and flag on every clock against a model built from segment lengths catches each of these at the first clock in which it diverges.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  localparam int TICK_W = 6;
  localparam int FRAME_CNT_W = 4;
  localparam int MIN_BITS = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } txState_t;

  typedef struct packed {
    logic load;
    logic shift;
  } txStrobe_t;

endpackage

// File: rtl/async_tx_datapath.sv
module async_tx_datapath
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  txStrobe_t              strobe,
  input  logic                   wrEn,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [DIV_W-1:0]       divisor,
  input  logic [1:0]             wordLen,
  input  logic                   twoStop,
  input  logic                   parityEn,
  input  logic                   parityOdd,
  output logic                   dataBit,
  output logic [FRAME_CNT_W-1:0] frameBits,
  output logic [TICK_W-1:0]      stopTicks,
  output logic [DIV_W:0]         divEff
);

  localparam int SHIFT_W = DATA_W + 1;

  logic [DATA_W-1:0]      holdReg;
  logic [SHIFT_W-1:0]     shiftReg;
  logic [SHIFT_W-1:0]     nextFrame;
  logic [FRAME_CNT_W-1:0] nData;
  logic [DATA_W-1:0]      dataMask;
  logic                   parBit;
  logic [TICK_W-1:0]      stopSel;

  always_comb begin
    nData = FRAME_CNT_W'(wordLen) + FRAME_CNT_W'(MIN_BITS);
    for (int i = 0; i < DATA_W; i++) begin
      dataMask[i] = (i < int'(nData));
    end
    parBit = (^(holdReg & dataMask)) ^ parityOdd;
    for (int i = 0; i < SHIFT_W; i++) begin
      if (i < int'(nData)) nextFrame[i] = holdReg[i % DATA_W];
      else if (i == int'(nData)) nextFrame[i] = parBit;
      else nextFrame[i] = 1'b0;
    end
    if (!twoStop) stopSel = TICK_W'(16);
    else if (wordLen == 2'd0) stopSel = TICK_W'(24);
    else stopSel = TICK_W'(32);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg   <= '0;
      shiftReg  <= '0;
      frameBits <= '0;
      stopTicks <= TICK_W'(16);
      divEff    <= (DIV_W+1)'(1);
    end else begin
      if (wrEn) holdReg <= wrData;
      if (strobe.load) begin
        shiftReg  <= nextFrame;
        frameBits <= nData + FRAME_CNT_W'(parityEn);
        stopTicks <= stopSel;
        divEff    <= (divisor == '0) ? {1'b1, {DIV_W{1'b0}}} : {1'b0, divisor};
      end else if (strobe.shift) begin
        shiftReg <= shiftReg >> 1;
      end
    end
  end

  assign dataBit = shiftReg[0];

endmodule

// File: rtl/async_tx_control.sv
module async_tx_control
  import async_tx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic                   dataBit,
  input  logic [FRAME_CNT_W-1:0] frameBits,
  input  logic [TICK_W-1:0]      stopTicks,
  input  logic [DIV_W:0]         divEff,
  output txStrobe_t              strobe,
  output logic                   txd,
  output logic                   holdEmpty,
  output logic                   txEmpty
);

  localparam int CNT_W = DIV_W + 1;

  txState_t               state;
  logic [CNT_W-1:0]       pre;
  logic [TICK_W-1:0]      tickCnt;
  logic [TICK_W-1:0]      tickLimit;
  logic [FRAME_CNT_W-1:0] bitsLeft;
  logic                   holdFull;
  logic                   tick;
  logic                   bitEnd;

  always_comb begin
    tick      = (state != ST_IDLE) && (pre == divEff - CNT_W'(1));
    tickLimit = (state == ST_STOP) ? stopTicks : TICK_W'(TICKS_PER_BIT);
    bitEnd    = tick && (tickCnt == tickLimit - TICK_W'(1));
    strobe.load  = holdFull && ((state == ST_IDLE) || ((state == ST_STOP) && bitEnd));
    strobe.shift = (state == ST_DATA) && bitEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pre      <= '0;
      tickCnt  <= '0;
      bitsLeft <= '0;
      holdFull <= 1'b0;
    end else begin
      if (wrEn) holdFull <= 1'b1;
      else if (strobe.load) holdFull <= 1'b0;

      if (strobe.load || state == ST_IDLE || tick) pre <= '0;
      else pre <= pre + CNT_W'(1);

      if (strobe.load || bitEnd) tickCnt <= '0;
      else if (tick) tickCnt <= tickCnt + TICK_W'(1);

      if (strobe.load) begin
        state <= ST_START;
      end else if (bitEnd) begin
        case (state)
          ST_START: begin
            state    <= ST_DATA;
            bitsLeft <= frameBits;
          end
          ST_DATA: begin
            bitsLeft <= bitsLeft - FRAME_CNT_W'(1);
            if (bitsLeft == FRAME_CNT_W'(1)) state <= ST_STOP;
          end
          ST_STOP: state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (state)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = dataBit;
      default:  txd = 1'b1;
    endcase
    holdEmpty = !holdFull;
    txEmpty   = (state == ST_IDLE) && !holdFull;
  end

endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [1:0]        wordLen,
  input  logic              twoStop,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              txd,
  output logic              holdEmpty,
  output logic              txEmpty
);

  txStrobe_t              strobe;
  logic                   dataBit;
  logic [FRAME_CNT_W-1:0] frameBits;
  logic [TICK_W-1:0]      stopTicks;
  logic [DIV_W:0]         divEff;

  async_tx_datapath #(.DATA_W(DATA_W), .DIV_W(DIV_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrEn(wrEn), .wrData(wrData),
    .divisor(divisor), .wordLen(wordLen), .twoStop(twoStop),
    .parityEn(parityEn), .parityOdd(parityOdd), .dataBit(dataBit),
    .frameBits(frameBits), .stopTicks(stopTicks), .divEff(divEff)
  );

  async_tx_control #(.DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .dataBit(dataBit),
    .frameBits(frameBits), .stopTicks(stopTicks), .divEff(divEff),
    .strobe(strobe), .txd(txd), .holdEmpty(holdEmpty), .txEmpty(txEmpty)
  );

endmodule

// File: rtl/async_tx_checker.sv
module async_tx_checker (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic txd,
  input logic holdEmpty,
  input logic txEmpty
);

  // R6: a quiet transmitter keeps the line at the stop level
  assert_idle_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> txd);

  // R7: a write fills the holding stage at the next edge
  assert_write_fills_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !holdEmpty);

  // R7: the transfer that empties the holding stage starts a frame with a low bit
  assert_transfer_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdEmpty) |-> !txd);

  // R9: without a write the transmitter stays quiet
  assert_stay_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    (txEmpty && !wrEn) |=> txEmpty);

  // R6: a frame finishes on a high line level
  assert_frame_ends_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEmpty) |-> (txd && $past(txd)));

endmodule

bind async_tx async_tx_checker uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .txd(txd),
  .holdEmpty(holdEmpty), .txEmpty(txEmpty)
);

// File: tb/sim_async_tx.sv
module sim_async_tx;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 190000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] divisor = 16'd1;
  logic [1:0]  wordLen = 2'd3;
  logic        twoStop = 1'b0;
  logic        parityEn = 1'b0;
  logic        parityOdd = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = 8'h00;
  logic        txd;
  logic        holdEmpty;
  logic        txEmpty;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string phase = "R1";

  // reference model state
  bit        mHoldFull;
  bit [7:0]  mHoldData;
  bit        mBusy;
  int        mRemain;
  bit        lvQ[$];
  int        durQ[$];
  string     tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  async_tx u0 (
    .clk(clk), .rstN(rstN), .divisor(divisor), .wordLen(wordLen),
    .twoStop(twoStop), .parityEn(parityEn), .parityOdd(parityOdd),
    .wrEn(wrEn), .wrData(wrData), .txd(txd), .holdEmpty(holdEmpty),
    .txEmpty(txEmpty)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (phase %s) at %0t: actual %0d expected %0d", req, phase, $time, act, exp);
    end
  endtask

  task automatic pushSeg(bit lv, int dur, string tag);
    lvQ.push_back(lv);
    durQ.push_back(dur);
    tagQ.push_back(tag);
  endtask

  task automatic buildFrame();
    int dv;
    int n;
    bit p;
    dv = (divisor == 16'd0) ? 65536 : int'(divisor);
    n = int'(wordLen) + 5;
    p = parityOdd;
    pushSeg(1'b0, 16 * dv, "R2");
    for (int i = 0; i < n; i++) begin
      pushSeg(mHoldData[i], 16 * dv, "R4");
      p ^= mHoldData[i];
    end
    if (parityEn) pushSeg(p, 16 * dv, "R5");
    if (!twoStop) pushSeg(1'b1, 16 * dv, "R6");
    else if (wordLen == 2'd0) pushSeg(1'b1, 24 * dv, "R6");
    else pushSeg(1'b1, 32 * dv, "R6");
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mHoldFull = 0;
      mHoldData = 0;
      mBusy = 0;
      mRemain = 0;
      lvQ.delete();
      durQ.delete();
      tagQ.delete();
    end else begin
      bit finishing;
      bit loadNow;
      finishing = mBusy && (mRemain == 1) && (lvQ.size() == 1);
      loadNow = mHoldFull && (!mBusy || finishing);
      if (mBusy) begin
        mRemain--;
        if (mRemain == 0) begin
          void'(lvQ.pop_front());
          void'(durQ.pop_front());
          void'(tagQ.pop_front());
          if (lvQ.size() > 0) mRemain = durQ[0];
          else mBusy = 0;
        end
      end
      if (loadNow) begin
        buildFrame();
        mBusy = 1;
        mRemain = durQ[0];
        mHoldFull = 0;
      end
      if (wrEn) begin
        mHoldData = wrData;
        mHoldFull = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit expTxd;
      string tg;
      expTxd = mBusy ? lvQ[0] : 1'b1;
      tg = mBusy ? tagQ[0] : "R9";
      chk(txd === expTxd, tg, int'(txd), int'(expTxd));
      chk(holdEmpty === !mHoldFull, "R7", int'(holdEmpty), int'(!mHoldFull));
      chk(txEmpty === (!mBusy && !mHoldFull), "R9", int'(txEmpty), int'(!mBusy && !mHoldFull));
    end
  end

  task automatic writeByte(logic [7:0] b);
    @(negedge clk); #1;
    wrEn = 1'b1;
    wrData = b;
    @(negedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    @(negedge clk);
    while (!txEmpty && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(txEmpty === 1'b1, "R9", int'(txEmpty), 1);
  endtask

  task automatic setFmt(logic [15:0] d, logic [1:0] wl, logic ts, logic pe, logic po);
    divisor = d;
    wordLen = wl;
    twoStop = ts;
    parityEn = pe;
    parityOdd = po;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    phase = "R1";
    chk(txd === 1'b1, "R1", int'(txd), 1);
    chk(holdEmpty === 1'b1, "R1", int'(holdEmpty), 1);
    chk(txEmpty === 1'b1, "R1", int'(txEmpty), 1);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(txd === 1'b1 && holdEmpty === 1'b1 && txEmpty === 1'b1, "R1", int'({txd, holdEmpty, txEmpty}), 7);

    // R2 R4: 8 bits, no parity, 1 stop, divisor 1
    phase = "R4";
    setFmt(16'd1, 2'd3, 1'b0, 1'b0, 1'b0);
    writeByte(8'hA5);
    waitIdle();

    // R5 R6: 5 bits even parity, 1.5 stop, divisor 2
    phase = "R5";
    setFmt(16'd2, 2'd0, 1'b1, 1'b1, 1'b0);
    writeByte(8'hF3);
    waitIdle();

    // R5 R6: 7 bits odd parity, 2 stop, divisor 3
    phase = "R6";
    setFmt(16'd3, 2'd2, 1'b1, 1'b1, 1'b1);
    writeByte(8'h5A);
    waitIdle();

    // 6 bits even parity, 2 stop
    phase = "R4";
    setFmt(16'd1, 2'd1, 1'b1, 1'b1, 1'b0);
    writeByte(8'hC7);
    waitIdle();

    // R7 R8 R10: chained frames, overwrite while held
    phase = "R8";
    setFmt(16'd1, 2'd3, 1'b0, 1'b1, 1'b1);
    writeByte(8'h11);
    writeByte(8'h22);
    phase = "R10";
    writeByte(8'h33);
    waitIdle();

    // R11: format change in mid frame
    phase = "R11";
    setFmt(16'd2, 2'd3, 1'b0, 1'b0, 1'b0);
    writeByte(8'h81);
    repeat (40) @(negedge clk);
    #1 setFmt(16'd1, 2'd0, 1'b1, 1'b1, 1'b1);
    waitIdle();
    writeByte(8'h0E);
    waitIdle();

    // R3: divisor 0 keeps the start bit low far beyond any short divisor
    phase = "R3";
    setFmt(16'd0, 2'd3, 1'b0, 1'b0, 1'b0);
    writeByte(8'hFF);
    repeat (20000) @(negedge clk);
    chk(txd === 1'b0, "R3", int'(txd), 0);
    #1 rstN = 1'b0;
    @(negedge clk);
    chk(txd === 1'b1 && holdEmpty === 1'b1 && txEmpty === 1'b1, "R1", int'({txd, holdEmpty, txEmpty}), 7);
    #1 rstN = 1'b1;
    repeat (4) @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog (phase %s): actual hung expected done", phase);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule